// File: doc/BRIEF.md
# Permission-Checked Address Translation Buffer

This block translates virtual addresses into physical addresses through a small, fully associative table of page mappings. Each table slot holds a virtual page number, a physical frame number and six permission bits. The permission bits grant read, write and instruction fetch separately for user and for supervisor privilege. A requester presents a virtual address, an access kind and a privilege level. One cycle later the block answers with either a physical address or a fault. A fault carries the offending virtual address and tells whether the page had no mapping or whether the mapping refused the access.

Software keeps the table up to date through two maintenance ports. One installs or replaces the mapping for a page. The other drops the mapping for a page. A global bypass input turns translation off: addresses then pass straight through and nothing is checked. Page size, address width and table capacity are parameters. Because the page size is a power of two, the page number and page offset are plain bit fields of the address.

Top module: `tlb_xlate_unit`

## Requirements
- R1: The access kind and privilege select one bit of the permission field. Kind 0 is read, kind 1 is write and kind 2 is fetch. Kind 3 selects no bit. With user privilege (`req_super`=0), read, write and fetch use bits 0, 1 and 2. With supervisor privilege, they use bits 3, 4 and 5.
- R2: When a lookup hits and the selected permission bit is set, the response carries the stored frame number in the upper bits and the request's page offset in the low bits. `rsp_fault`, `rsp_absent` and `rsp_fault_vaddr` are all 0.
- R3: When a lookup finds no valid slot for its page, the response has `rsp_fault`=1, `rsp_absent`=1, `rsp_paddr`=0, and `rsp_fault_vaddr` equal to the request address.
- R4: When a lookup hits but the selected permission bit is clear, the response has `rsp_fault`=1, `rsp_absent`=0, `rsp_paddr`=0, and `rsp_fault_vaddr` equal to the request address.
- R5: While `bypass_en` is 1, the response address equals the request address and no fault is raised, whatever the table holds.
- R6: `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid`=1, and it is 0 after reset. A lookup sees the table as it stood before any maintenance applied in the same cycle.
- R7: Installing a page that already has a slot overwrites that slot's frame number and permissions. No second slot is created.
- R8: Removing a page invalidates its slot. Removing a page that has no slot changes nothing.
- R9: A new page goes into the lowest-numbered free slot. When every slot is valid, a round-robin pointer picks the slot to replace. The pointer starts at 0 after reset and advances by one, wrapping, on each replacement.
- R10: When an install and a remove of the same page arrive in the same cycle, the install wins and the page stays mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Translation off: pass addresses through unchecked |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | ADDR_W | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| req_super | input | 1 | 1 for supervisor privilege |
| add_valid | input | 1 | Install strobe |
| add_vpn | input | ADDR_W-OFFS_W | Virtual page to install |
| add_pfn | input | ADDR_W-OFFS_W | Physical frame for that page |
| add_flags | input | 6 | Permission bits for that page |
| rm_valid | input | 1 | Remove strobe |
| rm_vpn | input | ADDR_W-OFFS_W | Virtual page to remove |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | ADDR_W | Translated address, or 0 on a fault |
| rsp_fault | output | 1 | The access faulted |
| rsp_absent | output | 1 | The fault was caused by a missing mapping |
| rsp_fault_vaddr | output | ADDR_W | Faulting virtual address, or 0 |

## Verification
Directed sequences fill the table completely and then keep adding pages. This separates lowest-free-slot placement from round-robin replacement, and a later remove shows that a freed slot is reused before the pointer moves. Lookups that cover every combination of kind and privilege against chosen permission patterns separate a missing mapping from a refused access, and catch a wrong bit position in the permission field. Randomized traffic over a small pool of pages forces frequent overwrites, removals of unmapped pages, and switches of the bypass mode. Same-cycle install-plus-remove and install-plus-lookup cases pin down the ordering rules.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PERM_W = 6;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/tlb_perm_mask.sv
module tlb_perm_mask
    import tlb_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic              super_mode,
    output logic [PERM_W-1:0] mask
);
    logic [2:0] base_d;

    always_comb begin
        unique case (acc_kind_e'(kind))
            ACC_READ:  base_d = 3'b001;
            ACC_WRITE: base_d = 3'b010;
            ACC_FETCH: base_d = 3'b100;
            default:   base_d = 3'b000;
        endcase
        mask = super_mode ? {base_d, 3'b000} : {3'b000, base_d};
    end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic              add_valid,
    input  logic [VPN_W-1:0]  add_vpn,
    input  logic [PFN_W-1:0]  add_pfn,
    input  logic [PERM_W-1:0] add_flags,
    input  logic              rm_valid,
    input  logic [VPN_W-1:0]  rm_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_flags
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]                valid;
        logic [ENTRIES-1:0][VPN_W-1:0]     vpn;
        logic [ENTRIES-1:0][PFN_W-1:0]     pfn;
        logic [ENTRIES-1:0][PERM_W-1:0]    flags;
        logic [IDX_W-1:0]                  rr;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    logic [ENTRIES-1:0] lk_match, add_match, rm_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign lk_match[g]  = st_q.valid[g] && (st_q.vpn[g] == lk_vpn);
        assign add_match[g] = st_q.valid[g] && (st_q.vpn[g] == add_vpn);
        assign rm_match[g]  = st_q.valid[g] && (st_q.vpn[g] == rm_vpn);
    end

    // read-out of the matching slot (at most one matches)
    always_comb begin
        lk_pfn   = '0;
        lk_flags = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                lk_pfn   = lk_pfn | st_q.pfn[i];
                lk_flags = lk_flags | st_q.flags[i];
            end
        end
        lk_hit = |lk_match;
    end

    logic [IDX_W-1:0] hit_idx_d, free_idx_d, tgt_idx_d;
    logic             free_any_d;

    always_comb begin
        hit_idx_d  = '0;
        free_idx_d = '0;
        free_any_d = ~&st_q.valid;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (add_match[i])    hit_idx_d  = IDX_W'(i);
            if (!st_q.valid[i])  free_idx_d = IDX_W'(i);
        end

        st_d = st_q;
        tgt_idx_d = st_q.rr;

        for (int i = 0; i < ENTRIES; i++) begin
            if (rm_valid && rm_match[i]) st_d.valid[i] = 1'b0;
        end

        if (add_valid) begin
            if (|add_match) begin
                tgt_idx_d = hit_idx_d;
            end else if (free_any_d) begin
                tgt_idx_d = free_idx_d;
            end else begin
                tgt_idx_d = st_q.rr;
                st_d.rr   = (st_q.rr == LAST_IDX) ? '0 : st_q.rr + 1'b1;
            end
            st_d.valid[tgt_idx_d] = 1'b1;
            st_d.vpn[tgt_idx_d]   = add_vpn;
            st_d.pfn[tgt_idx_d]   = add_pfn;
            st_d.flags[tgt_idx_d] = add_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_UNIQUE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)) else $error("duplicate page in table"); // R7

    AST_ADD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        add_valid |=> (st_q.valid & ~({ENTRIES{1'b0}})) != '0) else $error("install lost"); // R9

    AST_RM_ALONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_valid && !add_valid && (|rm_match)) |=> $countones(st_q.valid) == $countones($past(st_q.valid)) - 1)
        else $error("remove did not free a slot"); // R8

    AST_RM_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_valid && !add_valid && !(|rm_match)) |=> $stable(st_q.valid)) else $error("remove of absent page changed table"); // R8
endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
    import tlb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int ENTRIES    = 16,
    localparam int OFFS_W    = $clog2(PAGE_BYTES),
    localparam int PN_W      = ADDR_W - OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bypass_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_super,
    input  logic              add_valid,
    input  logic [PN_W-1:0]   add_vpn,
    input  logic [PN_W-1:0]   add_pfn,
    input  logic [PERM_W-1:0] add_flags,
    input  logic              rm_valid,
    input  logic [PN_W-1:0]   rm_vpn,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_absent,
    output logic [ADDR_W-1:0] rsp_fault_vaddr
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] paddr;
        logic              fault;
        logic              absent;
        logic [ADDR_W-1:0] fva;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [PERM_W-1:0] need_mask;
    logic              lk_hit;
    logic [PN_W-1:0]   lk_pfn;
    logic [PERM_W-1:0] lk_flags;
    logic              granted;

    tlb_perm_mask i_mask (
        .kind       (req_kind),
        .super_mode (req_super),
        .mask       (need_mask)
    );

    tlb_entry_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (PN_W),
        .PFN_W   (PN_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (req_vaddr[ADDR_W-1:OFFS_W]),
        .add_valid (add_valid),
        .add_vpn   (add_vpn),
        .add_pfn   (add_pfn),
        .add_flags (add_flags),
        .rm_valid  (rm_valid),
        .rm_vpn    (rm_vpn),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .lk_flags  (lk_flags)
    );

    assign granted = |(lk_flags & need_mask);

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (bypass_en) begin
                rsp_d.paddr = req_vaddr;
            end else if (lk_hit && granted) begin
                rsp_d.paddr = {lk_pfn, req_vaddr[OFFS_W-1:0]};
            end else begin
                rsp_d.fault  = 1'b1;
                rsp_d.absent = !lk_hit;
                rsp_d.fva    = req_vaddr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_paddr       = rsp_q.paddr;
    assign rsp_fault       = rsp_q.fault;
    assign rsp_absent      = rsp_q.absent;
    assign rsp_fault_vaddr = rsp_q.fva;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing response"); // R6

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("unrequested response"); // R6

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bypass_en) |=> (!rsp_fault && rsp_paddr == $past(req_vaddr))) else $error("bypass altered address"); // R5

    AST_GRANT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bypass_en && lk_hit && granted) |=> !rsp_fault) else $error("permitted access faulted"); // R2

    AST_REFUSE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !bypass_en && lk_hit && !granted) |=> (rsp_fault && !rsp_absent)) else $error("refusal misreported"); // R4

    AST_ABSENT_IS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_absent |-> (rsp_fault && rsp_valid)) else $error("absent without fault"); // R3
endmodule

// File: tb/test_tlb_xlate_unit.sv
module test_tlb_xlate_unit;
    localparam int ENT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bypass_en = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_super = 1'b0;
    logic        add_valid = 1'b0;
    logic [19:0] add_vpn = '0, add_pfn = '0;
    logic [5:0]  add_flags = '0;
    logic        rm_valid = 1'b0;
    logic [19:0] rm_vpn = '0;
    logic        rsp_valid, rsp_fault, rsp_absent;
    logic [31:0] rsp_paddr, rsp_fault_vaddr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tlb_xlate_unit i_tlb_xlate_unit (
        .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind), .req_super(req_super),
        .add_valid(add_valid), .add_vpn(add_vpn), .add_pfn(add_pfn), .add_flags(add_flags),
        .rm_valid(rm_valid), .rm_vpn(rm_vpn),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_absent(rsp_absent), .rsp_fault_vaddr(rsp_fault_vaddr)
    );

    // reference table built from the requirements
    bit          m_valid [ENT];
    logic [19:0] m_vpn   [ENT];
    logic [19:0] m_pfn   [ENT];
    logic [5:0]  m_flags [ENT];
    int          m_rr = 0;

    function automatic int m_find(logic [19:0] v);
        for (int i = 0; i < ENT; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    // R1 permission bit selection
    function automatic logic [5:0] need_bit(logic [1:0] k, logic s);
        logic [5:0] b;
        b = (k == 2'd3) ? 6'd0 : (6'd1 << k);
        return s ? (b << 3) : b;
    endfunction

    // {fault, absent, paddr, fault_vaddr}
    function automatic logic [65:0] expect_rsp(logic [31:0] va, logic [1:0] k, logic s, logic byp);
        int idx;
        if (byp) return {2'b00, va, 32'd0};                               // R5
        idx = m_find(va[31:12]);
        if (idx < 0) return {2'b11, 32'd0, va};                           // R3
        if ((m_flags[idx] & need_bit(k, s)) == 0) return {2'b10, 32'd0, va}; // R4
        return {2'b00, m_pfn[idx], va[11:0], 32'd0};                      // R2
    endfunction

    task automatic m_apply(bit da, logic [19:0] av, logic [19:0] ap, logic [5:0] af,
                           bit dr, logic [19:0] rv);
        int hit, tgt;
        hit = m_find(av);
        tgt = -1;
        if (da) begin
            if (hit >= 0) tgt = hit;
            else begin
                for (int i = ENT - 1; i >= 0; i--) if (!m_valid[i]) tgt = i;
                if (tgt < 0) begin tgt = m_rr; m_rr = (m_rr + 1) % ENT; end
            end
        end
        if (dr) begin
            int r;
            r = m_find(rv);
            if (r >= 0) m_valid[r] = 0;
        end
        if (da) begin
            m_valid[tgt] = 1; m_vpn[tgt] = av; m_pfn[tgt] = ap; m_flags[tgt] = af;
        end
    endtask

    task automatic check(string req, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic lookup(string req, logic [31:0] va, logic [1:0] k, logic s);
        logic [65:0] e;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = k; req_super = s;
        e = expect_rsp(va, k, s, bypass_en);
        @(negedge clk);
        req_valid = 0;
        check(req, {rsp_fault, rsp_absent, rsp_paddr, rsp_fault_vaddr}, e);
        check({req, " valid"}, {65'd0, rsp_valid}, 66'd1);
    endtask

    task automatic maint(bit da, logic [19:0] av, logic [19:0] ap, logic [5:0] af,
                         bit dr, logic [19:0] rv);
        @(negedge clk);
        add_valid = da; add_vpn = av; add_pfn = ap; add_flags = af;
        rm_valid = dr; rm_vpn = rv;
        @(negedge clk);
        add_valid = 0; rm_valid = 0;
        m_apply(da, av, ap, af, dr, rv);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < ENT; i++) m_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R6 reset", {rsp_valid, rsp_fault, rsp_absent, 63'd0}, 66'd0);

        // R3 empty table
        lookup("R3 empty miss", 32'h0000_5123, 2'd0, 1'b0);

        // R9 fill, then replacement order
        for (int i = 0; i < ENT; i++) maint(1, 20'h100 + 20'(i), 20'h800 + 20'(i), 6'h3F, 0, '0);
        lookup("R9 slot0 present", 32'h0010_0abc, 2'd0, 1'b0);
        lookup("R9 slot15 present", 32'h0010_fabc, 2'd2, 1'b1);
        maint(1, 20'h200, 20'h900, 6'h3F, 0, '0);
        lookup("R9 rr evicts slot0", 32'h0010_0abc, 2'd0, 1'b0);
        lookup("R9 new page mapped", 32'h0020_0004, 2'd1, 1'b0);
        maint(1, 20'h201, 20'h901, 6'h3F, 0, '0);
        lookup("R9 rr evicts slot1", 32'h0010_1000, 2'd0, 1'b0);
        // R8 remove frees slot, R9 reuse before pointer
        maint(0, '0, '0, '0, 1, 20'h105);
        lookup("R8 removed page absent", 32'h0010_5010, 2'd0, 1'b0);
        maint(1, 20'h202, 20'h902, 6'h3F, 0, '0);
        lookup("R9 freed slot reused, slot2 kept", 32'h0010_2fff, 2'd0, 1'b1);
        // R8 remove of unmapped page
        maint(0, '0, '0, '0, 1, 20'h777);
        lookup("R8 absent remove no effect", 32'h0010_3010, 2'd2, 1'b0);

        // R7 overwrite
        maint(1, 20'h104, 20'h555, 6'h01, 0, '0);
        lookup("R7 overwrite frame", 32'h0010_4321, 2'd0, 1'b0);
        lookup("R7 overwrite flags", 32'h0010_4321, 2'd1, 1'b0);

        // R1/R2/R4 every single-bit permission against every kind/privilege
        for (int b = 0; b < 6; b++) begin
            maint(1, 20'h104, 20'h5A5, 6'(1 << b), 0, '0);
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 2; s++)
                    lookup("R1 R2 R4 permission select", 32'h0010_4777, 2'(k), 1'(s));
        end

        // R10 install and remove of same page together
        maint(1, 20'h300, 20'hABC, 6'h3F, 1, 20'h300);
        lookup("R10 install wins", 32'h0030_0100, 2'd0, 1'b0);

        // R6 lookup sees pre-maintenance table
        @(negedge clk);
        req_valid = 1; req_vaddr = 32'h0040_0010; req_kind = 0; req_super = 0;
        add_valid = 1; add_vpn = 20'h400; add_pfn = 20'h111; add_flags = 6'h3F;
        @(negedge clk);
        req_valid = 0; add_valid = 0;
        check("R6 same-cycle install unseen", {rsp_fault, rsp_absent, rsp_paddr, rsp_fault_vaddr},
              {2'b11, 32'd0, 32'h0040_0010});
        m_apply(1, 20'h400, 20'h111, 6'h3F, 0, '0);
        lookup("R6 install seen after", 32'h0040_0010, 2'd0, 1'b0);

        // R5 bypass over mapped and unmapped pages
        bypass_en = 1;
        lookup("R5 bypass mapped", 32'h0040_0010, 2'd3, 1'b0);
        lookup("R5 bypass unmapped", 32'hDEAD_BEEF, 2'd1, 1'b1);
        bypass_en = 0;

        // randomized mix over a small page pool
        for (int n = 0; n < 600; n++) begin
            int unsigned op;
            logic [19:0] pg;
            op = $urandom % 10;
            pg = 20'h500 + 20'($urandom % 24);
            if (op < 3) maint(1, pg, 20'($urandom), 6'($urandom), 0, '0);
            else if (op < 4) maint(0, '0, '0, '0, 1, pg);
            else if (op < 5) begin
                bypass_en = ($urandom % 4) == 0;
                lookup("R2 R3 R4 R5 random", {pg, 12'($urandom)}, 2'($urandom), 1'($urandom));
                bypass_en = 0;
            end else lookup("R2 R3 R4 random", {pg, 12'($urandom)}, 2'($urandom), 1'($urandom));
        end

        @(negedge clk);
        check("R6 idle no response", {65'd0, rsp_valid}, 66'd0);
        finish_run();
    end
endmodule